// File: doc/BRIEF.md
# Interrupt Pending Register and Request Gate

This block holds the pending-interrupt field of a cause register for a small processor core and decides, once per clock, whether the core should see its single hard-interrupt request. Interrupt sources report level changes through one event port. Each event carries a line number and the new level of that line. Line numbers from 0 to 15 land in the cause register starting at bit 8. Larger numbers are discarded.

A free-running count/compare timer is built in. When the count steps onto the compare value, the timer sets line 7 (cause bit 15). Any write of a new compare value clears that bit again. An external interrupt controller is normally wired to line 2 (cause bit 10).

The request to the core is registered. It combines four things: the cause pending bits 8..15, the mask held in the same bit positions of a status register, a global enable in status bit 0, and three mode flags from the core (exception level, error level, debug). Any one of the three flags holds the request low. The request falls as soon as its condition fails, and nothing has to acknowledge it.

Top module: `irq_gate_unit`

## Requirements
- R1: An event with `req_valid` high and line number n in 0..15 writes `req_level` into cause bit n+8 at the next clock edge; level 1 sets the bit and level 0 clears it.
- R2: An event whose line number is 16 or more leaves every bit of `cause_o` unchanged.
- R3: `irq_o` is 1 only when status bit 0 is 1 and some bit position in 8..15 is 1 in both the status register and `cause_o`; cause bits 16..23 (lines 8..15) never raise the request.
- R4: While any of `exl_flag`, `erl_flag` or `dbg_flag` is 1 in a cycle, `irq_o` is 0 after the following clock edge, whatever is pending.
- R5: `irq_o` is a register. After each edge it reflects the status and cause values written at that edge together with the mode flags sampled at that edge. It falls with no acknowledge.
- R6: While `count_en` is 1, the 32-bit count advances by one per clock (it starts at 0). At the edge where the count becomes equal to the compare value, cause bit 15 is set.
- R7: A compare write (`cmp_we` high) stores `cmp_wdata` and clears cause bit 15 at the same edge.
- R8: For cause bit 15 the sources rank as follows: a compare write clears it first; otherwise a timer match sets it; otherwise an event on line 7 writes its level.
- R9: When `rst_n` is low, cause, status, count, compare and `irq_o` clear to zero at once, without waiting for a clock. The internal reset is released two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A level-change event is present |
| req_line | input | 5 | Line number of the event |
| req_level | input | 1 | New level of that line |
| status_we | input | 1 | Write strobe for the status register |
| status_wdata | input | 32 | Status value: mask in bits 8..15, global enable in bit 0 |
| cmp_we | input | 1 | Write strobe for the compare register |
| cmp_wdata | input | 32 | New compare value |
| count_en | input | 1 | Advance the count this cycle |
| exl_flag | input | 1 | Core is at exception level |
| erl_flag | input | 1 | Core is at error level |
| dbg_flag | input | 1 | Core is in debug mode |
| cause_o | output | 32 | Cause register contents (pending bits 8..23) |
| irq_o | output | 1 | Registered hard-interrupt request |

## Verification
Cause bit 15 can be driven by three sources in the same cycle: the timer match, a compare write, and an event on line 7. The bench steers the count so that it reaches the compare value in exactly the cycle where it also issues a compare write, and then again in a cycle where it issues a line-7 event at level 0. It also pairs a compare write with a line-7 event at level 1. A behavioural model applies the R8 ranking and is compared against `cause_o` and `irq_o` after every edge, so a wrong ranking appears as a mismatch on bit 15 and on the request.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  // Events the timer hands to the cause register for its own line.
  typedef struct packed {
    logic set;   // count has just stepped onto compare
    logic clr;   // compare register is being written
  } tmr_evt_t;

endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/irq_cmp_timer.sv
module irq_cmp_timer
  import irq_gate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_en,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] cmp_wdata,
  output logic [DATA_W-1:0] count_q,
  output logic [DATA_W-1:0] cmp_q,
  output tmr_evt_t          evt
);

  logic [DATA_W-1:0] count_inc;
  logic [DATA_W-1:0] count_d;
  logic [DATA_W-1:0] cmp_d;

  always_comb begin
    count_inc = count_q + DATA_W'(1);
    count_d   = count_en ? count_inc : count_q;
    cmp_d     = cmp_we ? cmp_wdata : cmp_q;
    evt.set   = count_en && (count_inc == cmp_q);
    evt.clr   = cmp_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      if (count_en) begin
        count_q <= count_d;
      end
      if (cmp_we) begin
        cmp_q <= cmp_d;
      end
    end
  end

endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_gate_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IP_OFS    = 8,
  parameter int IP_W      = 8,
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 5,
  parameter int TMR_LINE  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_level,
  input  tmr_evt_t          evt,
  output logic [IP_W-1:0]   ip_d,
  output logic [DATA_W-1:0] cause_q
);

  logic [DATA_W-1:0]    cause_d;
  logic [NUM_LINES-1:0] line_q;
  logic [NUM_LINES-1:0] line_d;
  logic [NUM_LINES-1:0] line_hit;
  logic                 in_range;
  logic                 cause_en;

  assign in_range = req_valid && (int'(req_line) < NUM_LINES);
  assign line_q   = cause_q[IP_OFS +: NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    assign line_hit[g] = in_range && (req_line == LINE_W'(g));
    if (g == TMR_LINE) begin : g_tmr
      // compare write beats a match, a match beats the event port
      assign line_d[g] = evt.clr     ? 1'b0 :
                         evt.set     ? 1'b1 :
                         line_hit[g] ? req_level : line_q[g];
    end else begin : g_ext
      assign line_d[g] = line_hit[g] ? req_level : line_q[g];
    end
  end

  always_comb begin
    cause_d = '0;
    cause_d[IP_OFS +: NUM_LINES] = line_d;
    ip_d     = cause_d[IP_OFS +: IP_W];
    cause_en = in_range | evt.set | evt.clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
  parameter int DATA_W  = 32,
  parameter int IP_OFS  = 8,
  parameter int IP_W    = 8,
  parameter int GIE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              status_we,
  input  logic [DATA_W-1:0] status_wdata,
  input  logic [IP_W-1:0]   ip_d,
  input  logic              exl_flag,
  input  logic              erl_flag,
  input  logic              dbg_flag,
  output logic [DATA_W-1:0] status_q,
  output logic              irq_q
);

  logic [DATA_W-1:0] status_d;
  logic [IP_W-1:0]   armed;
  logic              blocked;
  logic              irq_d;

  always_comb begin
    status_d = status_we ? status_wdata : status_q;
    armed    = status_d[IP_OFS +: IP_W] & ip_d;
    blocked  = exl_flag | erl_flag | dbg_flag;
    irq_d    = (|armed) && status_d[GIE_BIT] && !blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (status_we) begin
        status_q <= status_d;
      end
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit
  import irq_gate_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IP_OFS    = 8,
  parameter int IP_W      = 8,
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 5,
  parameter int TMR_LINE  = 7,
  parameter int GIE_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_level,
  input  logic              status_we,
  input  logic [DATA_W-1:0] status_wdata,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] cmp_wdata,
  input  logic              count_en,
  input  logic              exl_flag,
  input  logic              erl_flag,
  input  logic              dbg_flag,
  output logic [DATA_W-1:0] cause_o,
  output logic              irq_o
);

  logic              rst_sync_n;
  tmr_evt_t          tmr_evt;
  logic [DATA_W-1:0] count_q;
  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] status_q;
  logic [IP_W-1:0]   ip_d;

  irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_cmp_timer #(.DATA_W(DATA_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .count_en  (count_en),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .count_q   (count_q),
    .cmp_q     (cmp_q),
    .evt       (tmr_evt)
  );

  irq_cause_bank #(
    .DATA_W    (DATA_W),
    .IP_OFS    (IP_OFS),
    .IP_W      (IP_W),
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .TMR_LINE  (TMR_LINE)
  ) u_cause (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_line  (req_line),
    .req_level (req_level),
    .evt       (tmr_evt),
    .ip_d      (ip_d),
    .cause_q   (cause_o)
  );

  irq_req_gate #(
    .DATA_W  (DATA_W),
    .IP_OFS  (IP_OFS),
    .IP_W    (IP_W),
    .GIE_BIT (GIE_BIT)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .status_we    (status_we),
    .status_wdata (status_wdata),
    .ip_d         (ip_d),
    .exl_flag     (exl_flag),
    .erl_flag     (erl_flag),
    .dbg_flag     (dbg_flag),
    .status_q     (status_q),
    .irq_q        (irq_o)
  );

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int DATA_W    = 32,
  parameter int IP_OFS    = 8,
  parameter int IP_W      = 8,
  parameter int NUM_LINES = 16,
  parameter int LINE_W    = 5,
  parameter int TMR_LINE  = 7,
  parameter int GIE_BIT   = 0
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              req_valid,
  input logic [LINE_W-1:0] req_line,
  input logic              req_level,
  input logic              cmp_we,
  input logic              count_en,
  input logic              exl_flag,
  input logic              erl_flag,
  input logic              dbg_flag,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] count_q,
  input logic [DATA_W-1:0] cmp_q,
  input logic [DATA_W-1:0] cause_o,
  input logic              irq_o
);

  logic mode_hold;
  logic cond_now;
  logic match_now;

  assign mode_hold = exl_flag | erl_flag | dbg_flag;
  assign cond_now  = (|(status_q[IP_OFS +: IP_W] & cause_o[IP_OFS +: IP_W])) && status_q[GIE_BIT];
  assign match_now = count_en && ((count_q + DATA_W'(1)) == cmp_q);

  p_line_follow_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && (int'(req_line) < NUM_LINES) && (int'(req_line) != TMR_LINE))
      |=> (cause_o[IP_OFS + int'($past(req_line))] == $past(req_level)));

  p_high_ignore_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_valid && (int'(req_line) >= NUM_LINES) && !cmp_we && !count_en)
      |=> $stable(cause_o));

  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    irq_o |-> cond_now);

  p_mode_block_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    mode_hold |=> !irq_o);

  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (cond_now && !$past(mode_hold)) |-> irq_o);

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    count_en |=> (count_q == $past(count_q) + DATA_W'(1)));

  p_timer_set_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (match_now && !cmp_we) |=> cause_o[IP_OFS + TMR_LINE]);

  p_cmp_clear_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    cmp_we |=> !cause_o[IP_OFS + TMR_LINE]);

  p_match_over_req_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (match_now && !cmp_we && req_valid && (int'(req_line) == TMR_LINE) && !req_level)
      |=> cause_o[IP_OFS + TMR_LINE]);

endmodule

bind irq_gate_unit irq_gate_chk #(
  .DATA_W    (DATA_W),
  .IP_OFS    (IP_OFS),
  .IP_W      (IP_W),
  .NUM_LINES (NUM_LINES),
  .LINE_W    (LINE_W),
  .TMR_LINE  (TMR_LINE),
  .GIE_BIT   (GIE_BIT)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .req_valid (req_valid),
  .req_line  (req_line),
  .req_level (req_level),
  .cmp_we    (cmp_we),
  .count_en  (count_en),
  .exl_flag  (exl_flag),
  .erl_flag  (erl_flag),
  .dbg_flag  (dbg_flag),
  .status_q  (status_q),
  .count_q   (count_q),
  .cmp_q     (cmp_q),
  .cause_o   (cause_o),
  .irq_o     (irq_o)
);

// File: tb/tb_irq_gate_unit.sv
module tb_irq_gate_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [4:0]  req_line = '0;
  logic        req_level = 1'b0;
  logic        status_we = 1'b0;
  logic [31:0] status_wdata = '0;
  logic        cmp_we = 1'b0;
  logic [31:0] cmp_wdata = '0;
  logic        count_en = 1'b0;
  logic        exl_flag = 1'b0;
  logic        erl_flag = 1'b0;
  logic        dbg_flag = 1'b0;
  logic [31:0] cause_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [31:0] m_cause = '0;
  logic [31:0] m_status = '0;
  logic [31:0] m_count = '0;
  logic [31:0] m_cmp = '0;
  logic        m_irq = 1'b0;

  always #5 clk = ~clk;

  irq_gate_unit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_line     (req_line),
    .req_level    (req_level),
    .status_we    (status_we),
    .status_wdata (status_wdata),
    .cmp_we       (cmp_we),
    .cmp_wdata    (cmp_wdata),
    .count_en     (count_en),
    .exl_flag     (exl_flag),
    .erl_flag     (erl_flag),
    .dbg_flag     (dbg_flag),
    .cause_o      (cause_o),
    .irq_o        (irq_o)
  );

  task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cause = '0; m_status = '0; m_count = '0; m_cmp = '0; m_irq = 1'b0;
  endtask

  task automatic model_edge();
    logic [31:0] c;
    logic [31:0] st;
    c = m_cause;
    if (req_valid && (req_line < 5'd16)) c[int'(req_line) + 8] = req_level;
    if (count_en && (m_count + 32'd1 == m_cmp)) c[15] = 1'b1;
    if (cmp_we) c[15] = 1'b0;
    st = status_we ? status_wdata : m_status;
    m_irq = ((st[15:8] & c[15:8]) != 8'h00) && st[0] && !(exl_flag || erl_flag || dbg_flag);
    m_cause = c;
    m_status = st;
    if (count_en) m_count = m_count + 32'd1;
    if (cmp_we) m_cmp = cmp_wdata;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic rv, input logic [4:0] rl, input logic lv,
                     input logic swe, input logic [31:0] swd,
                     input logic cwe, input logic [31:0] cwd,
                     input logic cen, input string tag);
    req_valid = rv; req_line = rl; req_level = lv;
    status_we = swe; status_wdata = swd;
    cmp_we = cwe; cmp_wdata = cwd; count_en = cen;
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    check_eq({tag, " cause"}, cause_o, m_cause);
    check_eq({tag, " irq"}, {31'd0, irq_o}, {31'd0, m_irq});
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, tag);
  endtask

  task automatic line_ev(input logic [4:0] rl, input logic lv, input string tag);
    cyc(1'b1, rl, lv, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, tag);
  endtask

  task automatic wr_status(input logic [31:0] v, input string tag);
    cyc(1'b0, 5'd0, 1'b0, 1'b1, v, 1'b0, 32'd0, 1'b0, tag);
  endtask

  task automatic wr_cmp(input logic [31:0] v, input string tag);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 32'd0, 1'b1, v, 1'b0, tag);
  endtask

  task automatic tick(input string tag);
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: held in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R9 reset cause", cause_o, 32'h0);
    check_eq("R9 reset irq", {31'd0, irq_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) idle("R9 release");

    // R1: line 2 (controller) sets bit 10, nothing enabled yet
    line_ev(5'd2, 1'b1, "R1 line2 set");
    check_eq("R1 bit10", cause_o, 32'h0000_0400);
    check_eq("R3 no enable", {31'd0, irq_o}, 32'h0);
    // R3 R5: mask bit 10 plus global enable
    wr_status(32'h0000_0401, "R3 enable");
    check_eq("R5 irq up", {31'd0, irq_o}, 32'h1);
    line_ev(5'd2, 1'b0, "R1 line2 clr");
    check_eq("R5 irq drop", {31'd0, irq_o}, 32'h0);
    check_eq("R1 bit10 clr", cause_o, 32'h0);

    // R2: lines 16 and above are discarded
    line_ev(5'd18, 1'b1, "R2 line18");
    line_ev(5'd31, 1'b1, "R2 line31");
    line_ev(5'd16, 1'b1, "R2 line16");
    check_eq("R2 unchanged", cause_o, 32'h0);

    // R3: line 9 lands in bit 17, outside the gated field
    wr_status(32'h00FF_FF01, "R3 wide mask");
    line_ev(5'd9, 1'b1, "R3 line9");
    check_eq("R3 bit17", cause_o, 32'h0002_0000);
    check_eq("R3 bit17 no irq", {31'd0, irq_o}, 32'h0);
    line_ev(5'd9, 1'b0, "R1 line9 clr");

    // R4: mode flags hold the request low
    line_ev(5'd3, 1'b1, "R1 line3");
    check_eq("R3 line3 irq", {31'd0, irq_o}, 32'h1);
    exl_flag = 1'b1; idle("R4 exl");
    check_eq("R4 exl low", {31'd0, irq_o}, 32'h0);
    exl_flag = 1'b0; erl_flag = 1'b1; idle("R4 erl");
    check_eq("R4 erl low", {31'd0, irq_o}, 32'h0);
    erl_flag = 1'b0; dbg_flag = 1'b1; idle("R4 dbg");
    check_eq("R4 dbg low", {31'd0, irq_o}, 32'h0);
    dbg_flag = 1'b0; idle("R5 back");
    check_eq("R5 irq back", {31'd0, irq_o}, 32'h1);
    wr_status(32'h0000_FF00, "R3 gie off");
    check_eq("R3 gie off low", {31'd0, irq_o}, 32'h0);
    line_ev(5'd3, 1'b0, "R1 line3 clr");

    // R6: timer match on line 7
    wr_status(32'h0000_8001, "R6 mask15");
    wr_cmp(32'd5, "R7 cmp5");
    repeat (4) tick("R6 count");
    check_eq("R6 before match", cause_o, 32'h0);
    tick("R6 match");
    check_eq("R6 bit15", cause_o, 32'h0000_8000);
    check_eq("R6 irq", {31'd0, irq_o}, 32'h1);
    idle("R6 hold");
    wr_cmp(32'd9, "R7 cmp9");
    check_eq("R7 cleared", cause_o, 32'h0);
    check_eq("R7 irq low", {31'd0, irq_o}, 32'h0);

    // R8: the event port can also drive line 7
    line_ev(5'd7, 1'b1, "R8 line7 set");
    check_eq("R8 line7 bit15", cause_o, 32'h0000_8000);
    line_ev(5'd7, 1'b0, "R8 line7 clr");
    // count is 5, compare 9: match on the fourth step, write lands with it
    repeat (3) tick("R8 approach");
    cyc(1'b0, 5'd0, 1'b0, 1'b0, 32'd0, 1'b1, 32'd20, 1'b1, "R8 write vs match");
    check_eq("R8 write wins", cause_o, 32'h0);
    // count is 9; match at 12 together with a line-7 level-0 event
    wr_cmp(32'd12, "R7 cmp12");
    repeat (2) tick("R8 approach2");
    cyc(1'b1, 5'd7, 1'b0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b1, "R8 match vs event");
    check_eq("R8 match wins", cause_o, 32'h0000_8000);
    cyc(1'b1, 5'd7, 1'b1, 1'b0, 32'd0, 1'b1, 32'd40, 1'b0, "R8 write vs event");
    check_eq("R8 write over event", cause_o, 32'h0);

    // R9: asynchronous reset in mid-run
    wr_status(32'h0000_0401, "R9 prep");
    line_ev(5'd2, 1'b1, "R9 prep line");
    check_eq("R9 prep irq", {31'd0, irq_o}, 32'h1);
    #2 rst_n = 1'b0;
    #1;
    check_eq("R9 async cause", cause_o, 32'h0);
    check_eq("R9 async irq", {31'd0, irq_o}, 32'h0);
    model_reset();
    @(negedge clk);
    line_ev(5'd2, 1'b0, "R9 in reset");
    rst_n = 1'b1;
    repeat (3) idle("R9 release2");
    line_ev(5'd4, 1'b1, "R9 after");
    check_eq("R9 status cleared", {31'd0, irq_o}, 32'h0);
    check_eq("R1 line4", cause_o, 32'h0000_1000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule